// File: doc/BRIEF.md
# Pipelined Channel Demultiplexer Tree

This block takes one stream of tagged words from a shared source and delivers each word to one of sixteen channel output ports. Every input word carries a 4-bit channel code and a payload. The word travels down a binary tree of registered 1-to-2 splits. The root register steers on the most significant bit of the code, and each deeper level steers on the next lower bit. After four splits the word lands in the output register of its channel. Every node stores only the code bits that levels below it still need.

The input port and every output port use valid/ready flow control. Each node register holds one word and can take a new word in the same cycle that its child takes the current one. A stalled output therefore holds up only the words whose path runs through an occupied node on the way to that output. Each output is meant to feed a small per-channel FIFO.

Top module: `dmx_tree`

## Requirements
- R1: A word accepted with channel code c (0..15, `in_chan`) appears only on output port c (`out_valid[c]`, data in `out_data[16*c +: 16]` at the default width), and its payload is unchanged.
- R2: When every `out_ready` is high, a word accepted at clock edge a becomes visible on its output after edge a+4.
- R3: Words bound for the same channel leave that channel in the order they were accepted.
- R4: Every accepted word is delivered exactly once: nothing is lost and nothing is duplicated.
- R5: When every `out_ready` is high, `in_ready` is high, so one word per cycle can be accepted without gaps.
- R6: While `out_valid[c]` is high and `out_ready[c]` is low, `out_valid[c]` stays high and `out_data` for channel c does not change.
- R7: A word for channel d is delayed by a stalled channel only if its path meets an occupied node. When the paths do not meet, the word still arrives four edges after acceptance. A word whose path runs into a node held by the stalled word is not delivered until the stall clears.
- R8: When one channel is stalled and the input offers only words for that channel, exactly five words are accepted: one per register on its path. After that, `in_ready` stays low.
- R9: After reset, `in_ready` is high and every `out_valid` is low. No output becomes valid before a word has passed all five register stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word offered |
| in_chan | input | CH_W (4) | Destination channel code |
| in_data | input | DATA_W (16) | Input payload |
| in_ready | output | 1 | Root register can take a word this cycle |
| out_valid | output | 2**CH_W (16) | Per-channel output word present |
| out_data | output | 2**CH_W*DATA_W | Per-channel payloads, channel c at bits DATA_W*c upward |
| out_ready | input | 2**CH_W (16) | Per-channel consumer can take the word |

## Verification
A word with no backpressure is due on its output exactly four edges after the edge that accepted it. The bench stamps each accepted word with the number of its accepting edge and samples outputs at mid-cycle. It then requires the delivery cycle to be that edge plus four, both for single words and for a 64-word back-to-back stream. In the stall cases the bench waits a fixed number of cycles and then checks two things: which words have arrived and which have not, and that the held output did not change. After the stall is released, it checks that the held words come out in order and that every queue is empty.

// File: rtl/dmx_pkg.sv
`timescale 1ns/1ps
package dmx_pkg;

  // Tree level of heap-numbered node n (root is node 1, level 0).
  function automatic int lvl_of(input int n);
    int l;
    l = 0;
    for (int k = 1; k < 31; k++) begin
      if ((n >> k) != 0) l = k;
    end
    return l;
  endfunction

  // Code bits a node at level s still holds.
  function automatic int bits_at(input int ch_w, input int s);
    return ch_w - s;
  endfunction

  // Total code bits stored across all split nodes.
  function automatic int tag_total(input int ch_w);
    int t;
    t = 0;
    for (int l = 0; l < ch_w; l++) t += (1 << l) * bits_at(ch_w, l);
    return t;
  endfunction

  // Offset of node n's code bits inside the shared code pool.
  function automatic int tag_base(input int ch_w, input int n);
    int s;
    int off;
    s = lvl_of(n);
    off = 0;
    for (int l = 0; l < s; l++) off += (1 << l) * bits_at(ch_w, l);
    off += (n - (1 << s)) * bits_at(ch_w, s);
    return off;
  endfunction

endpackage

// File: rtl/dmx_split.sv
`timescale 1ns/1ps
// One registered 1-to-2 split: holds a word plus its remaining code bits,
// steers on the top stored bit.
module dmx_split #(
  parameter int TW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_v,
  input  logic [TW-1:0] in_tag,
  input  logic [DW-1:0] in_d,
  input  logic [1:0]    dn_ready,
  output logic          acc,
  output logic          q_v,
  output logic [TW-1:0] q_tag,
  output logic [DW-1:0] q_d
);
  logic sel;
  logic take;
  logic load;

  assign sel  = q_tag[TW-1];
  assign take = q_v & dn_ready[sel];
  assign acc  = ~q_v | take;
  assign load = in_v & acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_v <= 1'b0;
    else if (load) q_v <= 1'b1;
    else if (take) q_v <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      q_tag <= in_tag;
      q_d   <= in_d;
    end
  end
endmodule

// File: rtl/dmx_leaf.sv
`timescale 1ns/1ps
// Per-channel output register with valid/ready hand-off.
module dmx_leaf #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_v,
  input  logic [DW-1:0] in_d,
  input  logic          out_ready,
  output logic          acc,
  output logic          q_v,
  output logic [DW-1:0] q_d
);
  logic load;

  assign acc  = ~q_v | out_ready;
  assign load = in_v & acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 q_v <= 1'b0;
    else if (load)              q_v <= 1'b1;
    else if (q_v && out_ready)  q_v <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) q_d <= in_d;
  end
endmodule

// File: rtl/dmx_tree.sv
`timescale 1ns/1ps
module dmx_tree import dmx_pkg::*; #(
  parameter  int DATA_W  = 16,
  parameter  int CH_W    = 4,
  localparam int N_CH    = 1 << CH_W,
  localparam int N_SPLIT = N_CH - 1,
  localparam int N_NODE  = 2 * N_CH - 1,
  localparam int TAG_T   = tag_total(CH_W)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [CH_W-1:0]        in_chan,
  input  logic [DATA_W-1:0]      in_data,
  output logic                   in_ready,
  output logic [N_CH-1:0]        out_valid,
  output logic [N_CH*DATA_W-1:0] out_data,
  input  logic [N_CH-1:0]        out_ready
);
  // Heap numbering: node n has children 2n (bit 0) and 2n+1 (bit 1).
  logic [N_NODE:1]   node_v;    // occupancy of every register, seen by checker
  logic [N_NODE:1]   node_acc;  // node can take a word this cycle
  logic [N_NODE:1]   feed_v;    // word presented to node
  logic [N_SPLIT:1]  node_br;   // branch chosen by each split node
  logic [DATA_W-1:0] node_d [1:N_NODE];
  logic [TAG_T-1:0]  tag_pool;

  assign in_ready  = node_acc[1];
  assign feed_v[1] = in_valid;

  genvar n;
  generate
    for (n = 2; n <= N_NODE; n++) begin : g_feed
      assign feed_v[n] = node_v[n/2] & (node_br[n/2] == 1'(n % 2));
    end

    for (n = 1; n <= N_SPLIT; n++) begin : g_split
      localparam int LV = lvl_of(n);
      localparam int TW = bits_at(CH_W, LV);
      localparam int TB = tag_base(CH_W, n);
      logic [TW-1:0]     up_tag;
      logic [DATA_W-1:0] up_d;
      if (n == 1) begin : g_root
        assign up_tag = in_chan;
        assign up_d   = in_data;
      end else begin : g_inner
        localparam int PB = tag_base(CH_W, n / 2);
        // drop the bit the parent already used
        assign up_tag = tag_pool[PB +: TW];
        assign up_d   = node_d[n/2];
      end
      assign node_br[n] = tag_pool[TB + TW - 1];
      dmx_split #(.TW(TW), .DW(DATA_W)) u_node (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_v     (feed_v[n]),
        .in_tag   (up_tag),
        .in_d     (up_d),
        .dn_ready ({node_acc[2*n+1], node_acc[2*n]}),
        .acc      (node_acc[n]),
        .q_v      (node_v[n]),
        .q_tag    (tag_pool[TB +: TW]),
        .q_d      (node_d[n])
      );
    end

    for (n = 0; n < N_CH; n++) begin : g_leaf
      dmx_leaf #(.DW(DATA_W)) u_leaf (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_v      (feed_v[N_CH+n]),
        .in_d      (node_d[(N_CH+n)/2]),
        .out_ready (out_ready[n]),
        .acc       (node_acc[N_CH+n]),
        .q_v       (node_v[N_CH+n]),
        .q_d       (node_d[N_CH+n])
      );
      assign out_valid[n] = node_v[N_CH+n];
      assign out_data[n*DATA_W +: DATA_W] = node_d[N_CH+n];
    end
  endgenerate
endmodule

// File: rtl/dmx_tree_chk.sv
`timescale 1ns/1ps
module dmx_tree_chk #(
  parameter  int DATA_W = 16,
  parameter  int CH_W   = 4,
  localparam int N_CH   = 1 << CH_W,
  localparam int N_NODE = 2 * N_CH - 1,
  localparam int FW     = $clog2(N_NODE + 1) + 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [CH_W-1:0]        in_chan,
  input logic [N_CH-1:0]        out_valid,
  input logic [N_CH*DATA_W-1:0] out_data,
  input logic [N_CH-1:0]        out_ready,
  input logic [N_NODE:1]        occ
);
  logic [3:0]    since_rst;
  logic [3:0]    rdy_run;
  logic [FW-1:0] in_flight;
  logic [FW-1:0] n_out;

  assign n_out = FW'($countones(out_valid & out_ready));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      rdy_run   <= '0;
      in_flight <= '0;
    end else begin
      if (since_rst != 4'hf) since_rst <= since_rst + 4'd1;
      if (!(&out_ready))      rdy_run <= '0;
      else if (rdy_run != 4'hf) rdy_run <= rdy_run + 4'd1;
      in_flight <= in_flight + FW'(in_valid && in_ready) - n_out;
    end
  end

  // R9
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst <= 4'(CH_W)) |-> (out_valid == '0));

  // R5
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&out_ready) |-> in_ready);

  // R4
  conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    FW'($countones(occ)) == in_flight);

  genvar c;
  generate
    for (c = 0; c < N_CH; c++) begin : g_hold
      // R6
      hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[c] && !out_ready[c]) |=>
          (out_valid[c] && $stable(out_data[c*DATA_W +: DATA_W])));
    end
    if (CH_W == 4) begin : g_lat
      // R2
      latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4'd5 && rdy_run >= 4'd5 && $past(in_valid && in_ready, 5))
          |-> out_valid[$past(in_chan, 5)]);
    end
  endgenerate
endmodule

bind dmx_tree dmx_tree_chk #(.DATA_W(DATA_W), .CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_chan   (in_chan),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_ready (out_ready),
  .occ       (node_v)
);

// File: tb/dmx_tree_tb.sv
`timescale 1ns/1ps
module dmx_tree_tb;
  localparam int DW = 16;
  localparam int NC = 16;

  typedef struct {
    logic [DW-1:0] d;
    int            edge_no;
    bit            lat;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [3:0]        in_chan = '0;
  logic [DW-1:0]     in_data = '0;
  logic              in_ready;
  logic [NC-1:0]     out_valid;
  logic [NC*DW-1:0]  out_data;
  logic [NC-1:0]     out_ready = '1;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int last_acc = 0;
  item_t exp_q [NC][$];
  item_t got;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dmx_tree #(.DATA_W(DW), .CH_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected items as outputs are taken.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NC; c++) begin
        if (out_valid[c] && out_ready[c]) begin
          if (exp_q[c].size() == 0) begin
            check(0, "R4 unexpected word", c, -1);
          end else begin
            got = exp_q[c].pop_front();
            // R1 and R3: payload on port c matches the oldest word sent to c
            check(out_data[c*DW +: DW] == got.d, "R1/R3 payload",
                  int'(out_data[c*DW +: DW]), int'(got.d));
            if (got.lat) check(cyc - got.edge_no == 4, "R2 latency",
                               cyc - got.edge_no, 4);
          end
        end
      end
    end
  end

  // Driver: offer one word, push the expectation on acceptance.
  task automatic send(input int ch, input logic [DW-1:0] d, input bit lat);
    item_t it;
    in_valid = 1'b1;
    in_chan  = 4'(ch);
    in_data  = d;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    it.d = d; it.edge_no = cyc + 1; it.lat = lat;
    exp_q[ch].push_back(it);
    last_acc = cyc + 1;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    #400000;
    check(0, "watchdog", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int first_acc;
    int cnt;
    logic [DW-1:0] held;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(in_ready == 1'b1, "R9 in_ready", int'(in_ready), 1);
    check(out_valid == '0, "R9 out_valid", int'(out_valid), 0);
    @(posedge clk); #1;

    // R1, R2: one word per channel, every code value
    for (int c = 0; c < NC; c++) begin
      send(c, 16'h1000 + 16'(c * 17), 1'b1);
      idle(6);
    end

    // R5, R2, R3: back-to-back stream
    send(0, 16'h2000, 1'b1);
    first_acc = last_acc;
    for (int i = 1; i < 64; i++) send((i * 7) % NC, 16'h2000 + 16'(i), 1'b1);
    idle(8);
    check(last_acc - first_acc == 63, "R5 gapless stream", last_acc - first_acc, 63);

    // R8, R6: stall channel 7 and flood it
    out_ready = ~(16'h1 << 7);
    in_valid = 1'b1;
    in_chan = 4'd7;
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      in_data = 16'h7000 + 16'(cnt);
      @(negedge clk);
      if (in_ready) begin
        got.d = in_data; got.edge_no = cyc + 1; got.lat = 1'b0;
        exp_q[7].push_back(got);
        cnt++;
      end
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    check(cnt == 5, "R8 words taken while stalled", cnt, 5);
    @(negedge clk);
    check(in_ready == 1'b0, "R8 in_ready low", int'(in_ready), 0);
    held = out_data[7*DW +: DW];
    check(held == 16'h7000, "R6 first word held", int'(held), 16'h7000);
    repeat (3) @(negedge clk);
    check(out_valid[7] == 1'b1, "R6 valid held", int'(out_valid[7]), 1);
    check(out_data[7*DW +: DW] == held, "R6 data stable",
          int'(out_data[7*DW +: DW]), int'(held));
    @(posedge clk); #1;
    out_ready = '1;
    idle(10);
    check(exp_q[7].size() == 0, "R3/R4 channel 7 drained", exp_q[7].size(), 0);

    // R7: stall channel 3; channel 2 shares its level-3 node, channel 12 does not
    out_ready = ~(16'h1 << 3);
    send(3, 16'h3001, 1'b0);
    send(3, 16'h3002, 1'b0);
    send(2, 16'h3003, 1'b0);
    send(12, 16'h3004, 1'b1);
    idle(8);
    check(exp_q[12].size() == 0, "R7 free path delivered", exp_q[12].size(), 0);
    check(exp_q[2].size() == 1, "R7 shared path held", exp_q[2].size(), 1);
    check(exp_q[3].size() == 2, "R7 stalled channel held", exp_q[3].size(), 2);
    check(out_valid[3] == 1'b1, "R6 stalled output valid", int'(out_valid[3]), 1);
    out_ready = '1;
    idle(10);

    // R4: everything delivered once
    cnt = 0;
    for (int c = 0; c < NC; c++) cnt += exp_q[c].size();
    check(cnt == 0, "R4 all delivered", cnt, 0);
    check(out_valid == '0, "R4 outputs empty", int'(out_valid), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule